// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block keeps a single status word that tells software why the chip was last reset. Six reset sources feed it, each as a one-cycle event pulse: the external reset pin, power-on, brown-out, watchdog, a software request and a regulator fault. Software reads the word through a simple register port and acknowledges causes by writing zeros over the flags it has handled.

The recording rule is not symmetric. An external pin reset wipes the record and leaves only its own flag set. Every other cause ORs its flag into what is already held, so after a chain of internal resets software sees all of them together. The storage itself is only initialised by the power-up reset, which loads the power-on flag alone. The events it records never clear it.

The read port is combinational from the stored flags. A write takes effect at the next clock edge, and a hardware event in the same cycle wins over the write for its own bit.

Top module: `reset_cause_rec`

## Requirements
- R1: While `rst_n` is low, and after it is released with no event or write, `rd_data` reads 0x00000002, with only the power-on flag set.
- R2: The flags sit at these bit positions: bit 0 external pin, bit 1 power-on, bit 2 brown-out, bit 3 watchdog, bit 4 software, bit 5 regulator fault. A pulse on `cause_evt[i]` sets bit i at the next clock edge.
- R3: A pulse on `cause_evt[0]` makes the word read exactly 0x00000001 after the next edge. This holds whatever flags were held before, whatever other pulses arrive in the same cycle, and whatever is written in that cycle.
- R4: A pulse on any of `cause_evt[5:1]` without `cause_evt[0]` ORs its flag into the held flags and clears none of them.
- R5: With `wr_en` high, a 0 in `wr_data[i]` clears flag i and a 1 leaves flag i unchanged. The result is visible after the next edge.
- R6: When a write clears bit i and `cause_evt[i]` pulses in the same cycle, bit i ends set.
- R7: Bits 31:6 of `rd_data` always read zero, and writing ones to `wr_data[31:6]` has no effect.
- R8: With no event pulse and no write, the word holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| cause_evt | input | 6 | One-cycle cause pulses, same bit order as the status flags |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data. A 0 clears the matching flag |
| rd_data | output | 32 | Current status word |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and six cause flags. With these values every flag combination and every event/write overlap fits in the 6-bit space, and the randomized phase covers them. Bits 31:6 are also present, so the bench can write all ones into them and check that they still read zero. The reference model tracks the word as a plain integer, bit by bit, and compares it on every clock. This covers the directed corners and a long randomized run of mixed pulses and writes.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int CAUSE_N = 6;

  typedef logic [CAUSE_N-1:0] cause_t;

  typedef enum int {
    C_PIN   = 0,
    C_PWR   = 1,
    C_BROWN = 2,
    C_DOG   = 3,
    C_SOFT  = 4,
    C_REG   = 5
  } cause_idx_e;

  localparam int     EXT_IDX  = C_PIN;
  localparam cause_t PWR_INIT = cause_t'(1) << C_PWR;

  // Flags kept after a software write: a zero bit acknowledges (clears).
  function automatic cause_t keep_after_write(cause_t cur, logic we, cause_t wbits);
    return we ? (cur & wbits) : cur;
  endfunction
endpackage

// File: rtl/rcr_write_mask.sv
module rcr_write_mask
  import rcr_pkg::*;
(
  input  cause_t cur,
  input  logic   wr_en,
  input  cause_t wr_bits,
  output cause_t kept
);
  always_comb kept = keep_after_write(cur, wr_en, wr_bits);
endmodule

// File: rtl/rcr_event_merge.sv
module rcr_event_merge
  import rcr_pkg::*;
(
  input  cause_t kept,
  input  cause_t evt,
  output cause_t nxt,
  output logic   ext_hit
);
  assign ext_hit = evt[EXT_IDX];

  for (genvar i = 0; i < CAUSE_N; i++) begin : g_bit
    if (i == EXT_IDX) begin : g_ext
      assign nxt[i] = evt[i] | kept[i];
    end else begin : g_sticky
      // The external pin wipes every other cause; the others accumulate.
      assign nxt[i] = ~ext_hit & (kept[i] | evt[i]);
    end
  end
endmodule

// File: rtl/rcr_flag_store.sv
module rcr_flag_store
  import rcr_pkg::*;
#(
  parameter cause_t INIT = PWR_INIT
) (
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t nxt,
  output cause_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= INIT;
    else        q <= nxt;
  end
endmodule

// File: rtl/reset_cause_rec.sv
module reset_cause_rec
  import rcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CAUSE_N-1:0] cause_evt,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int RSVD_W = DATA_W - CAUSE_N;

  cause_t flags;
  cause_t wr_kept;
  cause_t flags_nxt;
  logic   ext_hit;

  rcr_write_mask u_wmask (
    .cur    (flags),
    .wr_en  (wr_en),
    .wr_bits(wr_data[CAUSE_N-1:0]),
    .kept   (wr_kept)
  );

  rcr_event_merge u_merge (
    .kept   (wr_kept),
    .evt    (cause_evt),
    .nxt    (flags_nxt),
    .ext_hit(ext_hit)
  );

  rcr_flag_store #(.INIT(PWR_INIT)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .nxt  (flags_nxt),
    .q    (flags)
  );

  assign rd_data = {{RSVD_W{1'b0}}, flags};
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker
  import rcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CAUSE_N-1:0] cause_evt,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              ext_hit
);
  // R3
  a_r3_ext_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> rd_data == DATA_W'(1));

  // R2, R4, R6: every pulsed non-external cause is set afterwards
  a_r4_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_evt[EXT_IDX] |=>
      ((rd_data[CAUSE_N-1:0] & $past(cause_evt)) == $past(cause_evt)));

  // R7
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:CAUSE_N] == '0);

  // R5: a zeroed bit with no matching event is clear after the write
  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cause_evt[EXT_IDX]) |=>
      ((rd_data[CAUSE_N-1:0] & ~$past(wr_data[CAUSE_N-1:0]) & ~$past(cause_evt)) == '0));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cause_evt == '0) |=> $stable(rd_data));

  // R4: no flag rises without its own event
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[CAUSE_N-1:0] & ~$past(rd_data[CAUSE_N-1:0]) & ~$past(cause_evt)) == '0));
endmodule

bind reset_cause_rec rcr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cause_evt(cause_evt),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .ext_hit  (ext_hit)
);

// File: tb/reset_cause_rec_test.sv
`timescale 1ns/1ps
module reset_cause_rec_test;
  localparam int DW = 32;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] cause_evt = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  longint model = 2;   // power-on flag only

  always #2.5 clk = ~clk;

  reset_cause_rec #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cause_evt(cause_evt),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input longint exp);
    n_tests++;
    if (longint'(rd_data) != exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=0x%08h expected 0x%08h", tag, rd_data, exp[31:0]);
    end
  endtask

  // Behavioural reference: one bit at a time, pin reset first.
  function automatic longint ref_next(longint cur, logic [NC-1:0] ev, logic we, logic [DW-1:0] wd);
    longint r = 0;
    if (ev[0]) return 1;
    for (int b = 0; b < NC; b++) begin
      bit held = cur[b];
      if (we && wd[b] == 1'b0) held = 0;
      if (ev[b]) held = 1;
      if (held) r = r + (longint'(1) << b);
    end
    return r;
  endfunction

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(input string tag, input logic [NC-1:0] ev,
                      input logic we, input logic [DW-1:0] wd);
    cause_evt = ev; wr_en = we; wr_data = wd;
    model = ref_next(model, ev, we, wd);
    @(posedge clk);
    @(negedge clk);
    cause_evt = '0; wr_en = 1'b0; wr_data = '0;
    check(tag, model);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 during reset", 2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 2);
    step("R1/R8 idle hold", '0, 0, '0);

    // R2: each non-pin cause lands on its own bit
    step("R2 brown-out bit2", 6'b000100, 0, '0);
    step("R2 watchdog bit3", 6'b001000, 0, '0);
    step("R2 software bit4", 6'b010000, 0, '0);
    step("R2 regulator bit5", 6'b100000, 0, '0);
    check("R4 accumulated 0x3E", 32'h3E);

    // R3: pin reset wipes the record
    step("R3 pin wipes", 6'b000001, 0, '0);
    check("R2 pin bit0 alone", 1);
    step("R4 power-on adds", 6'b000010, 0, '0);
    check("R4 pin kept with power-on", 3);
    step("R3 pin with others same cycle", 6'b111111, 0, '0);
    check("R3 only bit0", 1);
    step("R4 fill", 6'b111110, 0, '0);
    step("R3 pin beats write", 6'b000001, 1, 32'h0);
    check("R3 bit0 after write clash", 1);

    // R5: write acknowledges
    step("R4 fill again", 6'b111110, 0, '0);
    step("R5 clear bits 1,3", '0, 1, 32'hFFFF_FFF5);
    check("R5 cleared 1 and 3", 32'h35);
    step("R5 write all ones no change", '0, 1, 32'hFFFF_FFFF);
    check("R7 reserved stays zero", 32'h35);
    step("R6 event beats clear", 6'b010000, 1, 32'h0);
    check("R6 software bit survives", 32'h10);
    step("R5 clear all", '0, 1, 32'h0);
    check("R5 word zero", 0);
    repeat (3) step("R8 hold zero", '0, 0, '0);

    // Mixed random phase, compared every clock
    for (int k = 0; k < 400; k++) begin
      logic [NC-1:0] ev = NC'($urandom);
      logic          we = 1'($urandom);
      logic [DW-1:0] wd = $urandom;
      if (($urandom % 4) != 0) ev[0] = 1'b0;
      if (($urandom % 3) == 0) ev = '0;
      step("R2/R4/R5/R6 random", ev, we, wd);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule